// File: doc/BRIEF.md
# Multiturn Position Counter with Target Interrupt

This block tracks an absolute position made of an 8-bit fine value and a 24-bit turn counter. It receives step and direction events from an upstream interpolator. The fine value moves by one on every step. The turn counter either follows roll-overs of the fine value or counts every step, depending on a mode input. The counter can be held at zero, cleared by a zero pulse, and enabled either by a register bit or by an external pin.

The combined 32-bit position is compared against a target. The number of low bytes that take part in the compare is selectable. Four status bits record events:

- output changed
- target reached
- input too fast
- phase jump between the coarse quadrature tracks

Per-bit enables route these bits to an active-high interrupt line and an active-low error line. The status bits can be shown live or latched. A speed register holds the ones complement of the number of clocks between consecutive output changes, so a faster motion reads as a larger value.

Top module: `multiturn_tracker`

## Requirements
- R1: During and right after reset, fineVal, countVal, statusByte and speedVal are 0, intOut is 0 and errN is 1.
- R2: A clock with stepValid high changes fineVal by +1 (stepUp=1) or -1 (stepUp=0), modulo 256. The new value is visible after that clock edge.
- R3: With stepMode=0 and counting enabled, countVal rises by one on an up-step from fine 255 and falls by one on a down-step from fine 0. countVal wraps modulo 2^24 in both directions.
- R4: With stepMode=1 and counting enabled, countVal changes by one in the step direction on every step.
- R5: Counting is enabled by cntEnPin when cntEnSel=1, and by cntEnReg otherwise. While counting is disabled, countVal holds and fineVal still moves.
- R6: clrCnt=1 forces countVal to 0. clrOnZero=1 together with zeroPulse=1 also forces countVal to 0. A clear wins over a step in the same clock.
- R7: statusByte bit 0 (change) is set in the clock after an accepted step. With latchInt=0 it stays high for exactly one clock per step.
- R8: statusByte bit 1 (target) is set when the new position {countVal,fineVal} equals target on its low (outLen+1) bytes. Bits 7:0 are always compared; outLen=3 compares all 32 bits.
- R9: statusByte bit 3 (phase jump) is set when trkA and trkB both differ from their values sampled one clock earlier. Bit 2 (overspeed) follows the overspeed input with one clock of delay. Bits 7:4 read 0.
- R10: With latchInt=0 (bits 1:0) or latchErr=0 (bits 3:2), a status bit reflects its cause of the previous clock. With the latch bit at 1, a set status bit stays set. Driving the latch bit 1, then 0, then 1 discards stale events.
- R11: intOut is the OR of statusByte[1:0] masked by intEn[1:0], and is forced to 0 while cntEnSel=1. errN is low when statusByte[3:2] masked by errEn[1:0] is non-zero.
- R12: On each step, speedVal is loaded with the ones complement of the number of clocks since the previous step. The count saturates at 255, so the first step after reset, or a step after 255 or more idle clocks, loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepValid | input | 1 | One interpolation step in this clock |
| stepUp | input | 1 | Step direction, 1 = up |
| trkA | input | 1 | Coarse quadrature track A |
| trkB | input | 1 | Coarse quadrature track B |
| zeroPulse | input | 1 | Prepared zero/index pulse |
| cntEnPin | input | 1 | External count enable |
| overspeed | input | 1 | Input too fast for the resolution |
| stepMode | input | 1 | 1 = count every step, 0 = count fine roll-overs |
| cntEnSel | input | 1 | 1 = enable from pin, 0 = from cntEnReg |
| cntEnReg | input | 1 | Register count enable |
| clrCnt | input | 1 | Hold counter at zero |
| clrOnZero | input | 1 | Clear counter on zeroPulse |
| outLen | input | 2 | Compare depth in bytes minus one |
| target | input | 32 | Target position |
| intEn | input | 2 | Interrupt enables for status bits 1:0 |
| errEn | input | 2 | Error enables for status bits 3:2 |
| latchInt | input | 1 | Latch control for status bits 1:0 |
| latchErr | input | 1 | Latch control for status bits 3:2 |
| fineVal | output | 8 | Fine position |
| countVal | output | 24 | Turn counter |
| statusByte | output | 8 | Status bits, 7:4 zero |
| speedVal | output | 8 | Ones complement of the clocks between changes |
| intOut | output | 1 | Interrupt, active high |
| errN | output | 1 | Error, active low |

## Verification
Every registered result is due one edge after its stimulus is sampled: position, counter, speed and status appear together after the same clock edge. intOut and errN follow the status register without further delay. The bench drives inputs one nanosecond after a rising edge and samples every output one nanosecond after the next rising edge. Each output is compared against a cycle model that advances once per edge. Directed sequences pin the counter wrap, the latch clear sequence and speed saturation at exact clock positions.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef struct packed {
    logic fineStep;
    logic fineUp;
    logic cntInc;
    logic cntDec;
    logic cntClr;
    logic speedLoad;
  } mtStrobe_t;

  localparam int STAT_BITS = 4;
endpackage

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
#(
  parameter int FINE_W  = 8,
  parameter int COUNT_W = 24,
  parameter int TICK_W  = 8,
  localparam int POS_W  = FINE_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  mtStrobe_t          strobe,
  output logic [FINE_W-1:0]  fineQ,
  output logic [COUNT_W-1:0] countQ,
  output logic [TICK_W-1:0]  speedQ,
  output logic [POS_W-1:0]   posNext
);
  logic [FINE_W-1:0]  fineNext;
  logic [COUNT_W-1:0] countNext;
  logic [TICK_W-1:0]  tickQ;
  logic [TICK_W-1:0]  tickNext;

  always_comb begin
    fineNext = fineQ;
    if (strobe.fineStep) begin
      fineNext = strobe.fineUp ? fineQ + FINE_W'(1) : fineQ - FINE_W'(1);
    end
    countNext = countQ;
    if (strobe.cntClr) begin
      countNext = '0;
    end else if (strobe.cntInc) begin
      countNext = countQ + COUNT_W'(1);
    end else if (strobe.cntDec) begin
      countNext = countQ - COUNT_W'(1);
    end
    if (strobe.speedLoad) begin
      tickNext = TICK_W'(1);
    end else if (tickQ == '1) begin
      tickNext = tickQ;
    end else begin
      tickNext = tickQ + TICK_W'(1);
    end
  end

  assign posNext = {countNext, fineNext};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineQ  <= '0;
      countQ <= '0;
      tickQ  <= '1;
      speedQ <= '0;
    end else begin
      fineQ  <= fineNext;
      countQ <= countNext;
      tickQ  <= tickNext;
      if (strobe.speedLoad) begin
        speedQ <= ~tickQ;
      end
    end
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> countQ == '0);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntClr && countQ == '1) |=> countQ == '0);

  assert_fine_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fineStep && strobe.fineUp) |=> fineQ == FINE_W'($past(fineQ) + FINE_W'(1)));

  assert_speed_sat_R12: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ == '1 && !strobe.speedLoad) |=> tickQ == '1);
endmodule

// File: rtl/mt_control.sv
module mt_control
  import mt_pkg::*;
#(
  parameter int FINE_W = 8,
  parameter int POS_W  = 32,
  localparam int BYTES = POS_W / 8,
  localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepValid,
  input  logic                 stepUp,
  input  logic                 trkA,
  input  logic                 trkB,
  input  logic                 zeroPulse,
  input  logic                 cntEnPin,
  input  logic                 overspeed,
  input  logic                 stepMode,
  input  logic                 cntEnSel,
  input  logic                 cntEnReg,
  input  logic                 clrCnt,
  input  logic                 clrOnZero,
  input  logic [SEL_W-1:0]     outLen,
  input  logic [POS_W-1:0]     target,
  input  logic [1:0]           intEn,
  input  logic [1:0]           errEn,
  input  logic                 latchInt,
  input  logic                 latchErr,
  input  logic [FINE_W-1:0]    fineQ,
  input  logic [POS_W-1:0]     posNext,
  output mtStrobe_t            strobe,
  output logic [STAT_BITS-1:0] statusQ,
  output logic                 intOut,
  output logic                 errN
);
  logic cntEn, clrNow, rollNow, stepErr, posMatch;
  logic trkAPrev, trkBPrev;
  logic [BYTES-1:0] byteHit;
  logic [1:0] intCause, errCause;

  assign cntEn   = cntEnSel ? cntEnPin : cntEnReg;
  assign clrNow  = clrCnt || (clrOnZero && zeroPulse);
  assign rollNow = stepMode || (stepUp ? (fineQ == '1) : (fineQ == '0));

  always_comb begin
    strobe.fineStep  = stepValid;
    strobe.fineUp    = stepUp;
    strobe.cntClr    = clrNow;
    strobe.cntInc    = stepValid && cntEn && rollNow && stepUp && !clrNow;
    strobe.cntDec    = stepValid && cntEn && rollNow && !stepUp && !clrNow;
    strobe.speedLoad = stepValid;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_cmp
    logic inDepth;
    assign inDepth    = (i <= int'(outLen));
    assign byteHit[i] = !inDepth || (posNext[i*8 +: 8] == target[i*8 +: 8]);
  end
  assign posMatch = &byteHit;

  assign stepErr  = (trkA != trkAPrev) && (trkB != trkBPrev);
  assign intCause = {posMatch, stepValid};
  assign errCause = {stepErr, overspeed};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkAPrev <= 1'b0;
      trkBPrev <= 1'b0;
      statusQ  <= '0;
    end else begin
      trkAPrev     <= trkA;
      trkBPrev     <= trkB;
      statusQ[1:0] <= latchInt ? (statusQ[1:0] | intCause) : intCause;
      statusQ[3:2] <= latchErr ? (statusQ[3:2] | errCause) : errCause;
    end
  end

  assign intOut = !cntEnSel && |(statusQ[1:0] & intEn);
  assign errN   = !(|(statusQ[3:2] & errEn));

  assert_phase_jump_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((trkA != trkAPrev) && (trkB != trkBPrev)) |=> statusQ[3]);

  assert_change_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!latchInt && !stepValid) |=> !statusQ[0]);

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[1] && latchInt) ##1 latchInt |-> statusQ[1]);

  assert_no_dual_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntInc && strobe.cntDec));
endmodule

// File: rtl/multiturn_tracker.sv
module multiturn_tracker
  import mt_pkg::*;
#(
  parameter int FINE_W  = 8,
  parameter int COUNT_W = 24,
  parameter int TICK_W  = 8,
  localparam int POS_W  = FINE_W + COUNT_W,
  localparam int BYTES  = POS_W / 8,
  localparam int SEL_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  logic               stepUp,
  input  logic               trkA,
  input  logic               trkB,
  input  logic               zeroPulse,
  input  logic               cntEnPin,
  input  logic               overspeed,
  input  logic               stepMode,
  input  logic               cntEnSel,
  input  logic               cntEnReg,
  input  logic               clrCnt,
  input  logic               clrOnZero,
  input  logic [SEL_W-1:0]   outLen,
  input  logic [POS_W-1:0]   target,
  input  logic [1:0]         intEn,
  input  logic [1:0]         errEn,
  input  logic               latchInt,
  input  logic               latchErr,
  output logic [FINE_W-1:0]  fineVal,
  output logic [COUNT_W-1:0] countVal,
  output logic [7:0]         statusByte,
  output logic [TICK_W-1:0]  speedVal,
  output logic               intOut,
  output logic               errN
);
  mtStrobe_t              strobe;
  logic [STAT_BITS-1:0]   statusQ;
  logic [POS_W-1:0]       posNext;

  mt_control #(.FINE_W(FINE_W), .POS_W(POS_W)) u_ctrl (
    .clk, .rstN, .stepValid, .stepUp, .trkA, .trkB, .zeroPulse, .cntEnPin,
    .overspeed, .stepMode, .cntEnSel, .cntEnReg, .clrCnt, .clrOnZero, .outLen,
    .target, .intEn, .errEn, .latchInt, .latchErr,
    .fineQ(fineVal), .posNext, .strobe, .statusQ, .intOut, .errN
  );

  mt_datapath #(.FINE_W(FINE_W), .COUNT_W(COUNT_W), .TICK_W(TICK_W)) u_dp (
    .clk, .rstN, .strobe,
    .fineQ(fineVal), .countQ(countVal), .speedQ(speedVal), .posNext
  );

  assign statusByte = {{(8-STAT_BITS){1'b0}}, statusQ};

  assert_int_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntEnSel |-> !intOut);
endmodule

// File: tb/multiturn_tracker_bench.sv
`timescale 1ns/1ps
module multiturn_tracker_bench;
  logic clk = 0, rstN = 0;
  logic stepValid = 0, stepUp = 0, trkA = 0, trkB = 0, zeroPulse = 0, cntEnPin = 0;
  logic overspeed = 0, stepMode = 0, cntEnSel = 0, cntEnReg = 0, clrCnt = 0, clrOnZero = 0;
  logic [1:0] outLen = 0, intEn = 0, errEn = 0;
  logic [31:0] target = 0;
  logic latchInt = 0, latchErr = 0;
  logic [7:0] fineVal, statusByte, speedVal;
  logic [23:0] countVal;
  logic intOut, errN;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [7:0] mFine, mTick, mSpeed;
  logic [23:0] mCount;
  logic [3:0] mStat;
  logic mPrevA, mPrevB;

  always #2 clk = ~clk;

  multiturn_tracker u_multiturn_tracker (
    .clk, .rstN, .stepValid, .stepUp, .trkA, .trkB, .zeroPulse, .cntEnPin,
    .overspeed, .stepMode, .cntEnSel, .cntEnReg, .clrCnt, .clrOnZero, .outLen,
    .target, .intEn, .errEn, .latchInt, .latchErr,
    .fineVal, .countVal, .statusByte, .speedVal, .intOut, .errN
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] depthMask(input logic [1:0] len);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (i <= int'(len)) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic modelEdge();
    logic en, clr, roll, cmp, jump;
    logic [1:0] ic, ec;
    logic [7:0] oldFine;
    en = cntEnSel ? cntEnPin : cntEnReg;
    clr = clrCnt || (clrOnZero && zeroPulse);
    oldFine = mFine;
    roll = stepMode || (stepUp ? (oldFine == 8'hFF) : (oldFine == 8'h00));
    if (stepValid) mFine = stepUp ? oldFine + 8'd1 : oldFine - 8'd1;
    if (clr) mCount = '0;
    else if (stepValid && en && roll) mCount = stepUp ? mCount + 24'd1 : mCount - 24'd1;
    cmp = ((({mCount, mFine}) ^ target) & depthMask(outLen)) == 32'd0;
    jump = (trkA != mPrevA) && (trkB != mPrevB);
    mPrevA = trkA; mPrevB = trkB;
    ic = {cmp, stepValid};
    ec = {jump, overspeed};
    mStat[1:0] = latchInt ? (mStat[1:0] | ic) : ic;
    mStat[3:2] = latchErr ? (mStat[3:2] | ec) : ec;
    if (stepValid) begin
      mSpeed = ~mTick;
      mTick = 8'd1;
    end else if (mTick != 8'hFF) begin
      mTick = mTick + 8'd1;
    end
  endtask

  task automatic compareAll();
    chk("R2 fine", {24'd0, fineVal}, {24'd0, mFine});
    chk("R3/R4/R5/R6 count", {8'd0, countVal}, {8'd0, mCount});
    chk("R7/R8/R9/R10 status", {24'd0, statusByte}, {28'd0, mStat});
    chk("R12 speed", {24'd0, speedVal}, {24'd0, mSpeed});
    chk("R11 intOut", {31'd0, intOut}, {31'd0, !cntEnSel && |(mStat[1:0] & intEn)});
    chk("R11 errN", {31'd0, errN}, {31'd0, !(|(mStat[3:2] & errEn))});
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mFine = 0; mCount = 0; mStat = 0; mTick = 8'hFF; mSpeed = 0; mPrevA = 0; mPrevB = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 fine", {24'd0, fineVal}, 32'd0);
    chk("R1 count", {8'd0, countVal}, 32'd0);
    chk("R1 status", {24'd0, statusByte}, 32'd0);
    chk("R1 speed", {24'd0, speedVal}, 32'd0);
    chk("R1 pins", {30'd0, intOut, errN}, 32'd1);
    rstN = 1;

    // R3 and R4: step mode down from zero wraps to all ones, then back up
    cntEnReg = 1; stepMode = 1; stepValid = 1; stepUp = 0;
    cycle();
    chk("R3 wrap down", {8'd0, countVal}, 32'h00FF_FFFF);
    chk("R12 first step speed", {24'd0, speedVal}, 32'd0);
    stepUp = 1;
    cycle();
    chk("R3 wrap up", {8'd0, countVal}, 32'd0);
    chk("R12 one clock gap", {24'd0, speedVal}, 32'h0000_00FE);

    // R3: normal mode counts only on fine roll-over
    stepMode = 0;
    repeat (256) cycle();
    chk("R3 fine roll", {8'd0, countVal}, 32'd1);

    // R6: clear wins over a step
    stepMode = 1; clrCnt = 1;
    cycle();
    chk("R6 clear", {8'd0, countVal}, 32'd0);
    clrCnt = 0;

    // R10: latched change bit survives, cleared by 1,0,1
    stepValid = 0; latchInt = 1; intEn = 2'b01;
    stepValid = 1; cycle();
    stepValid = 0; cycle(); cycle();
    chk("R10 latched held", {31'd0, statusByte[0]}, 32'd1);
    chk("R11 int from latched", {31'd0, intOut}, 32'd1);
    latchInt = 0; cycle();
    latchInt = 1; cycle();
    chk("R10 cleared by 1-0-1", {31'd0, statusByte[0]}, 32'd0);
    latchInt = 0;

    // R12: saturation after long idle
    repeat (300) cycle();
    stepValid = 1; cycle();
    chk("R12 saturated", {24'd0, speedVal}, 32'd0);
    stepValid = 0;

    // R9: both tracks toggle together
    errEn = 2'b10; trkA = 1; trkB = 1; cycle();
    chk("R9 phase jump", {31'd0, statusByte[3]}, 32'd1);
    chk("R11 errN low", {31'd0, errN}, 32'd0);
    cycle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 40 == 0) begin
        stepMode  = $urandom_range(0, 1);
        cntEnSel  = $urandom_range(0, 1);
        cntEnReg  = $urandom_range(0, 3) != 0;
        clrOnZero = $urandom_range(0, 1);
        outLen    = 2'($urandom_range(0, 3));
        intEn     = 2'($urandom_range(0, 3));
        errEn     = 2'($urandom_range(0, 3));
        latchInt  = $urandom_range(0, 3) == 0;
        latchErr  = $urandom_range(0, 3) == 0;
      end
      stepValid = $urandom_range(0, 9) < 6;
      if ($urandom_range(0, 9) == 0) stepUp = ~stepUp;
      cntEnPin  = $urandom_range(0, 3) != 0;
      zeroPulse = $urandom_range(0, 29) == 0;
      clrCnt    = $urandom_range(0, 99) == 0;
      overspeed = $urandom_range(0, 19) == 0;
      if ($urandom_range(0, 4) == 0) trkA = ~trkA;
      if ($urandom_range(0, 4) == 0) trkB = ~trkB;
      if ($urandom_range(0, 7) == 0)
        target = {mCount, 8'(mFine + 8'($urandom_range(0, 4)) - 8'd2)};
      cycle();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule